// File: doc/BRIEF.md
# Exhaustive Truth-Table Test Sequencer

This block finds the full truth table of an external combinational circuit by itself. Before a run, the configuration inputs set how many circuit inputs are in use (N) and a settle delay in clock cycles. A start pulse then begins a sweep. The sequencer applies each pattern from 0 to 2^N-1 in turn on an 8-bit pattern bus and holds it for the settle time. It then takes the circuit's single-bit response and writes a record for that pattern into an internal 256-entry table.

The response bit comes from outside the clock domain, so it passes through a two-stage synchronizer. The settle timer adds the synchronizer's latency to the programmed delay. As a result, the stored bit is the response that was present while the pattern stood on the bus. When the sweep ends, a one-cycle done pulse is raised. The table can then be read by address through a registered read port.

Top module: `ttab_sweeper`

## Requirements
- R1: During reset and whenever the block is idle, `busy`, `done` and `pat_out` are all low.
- R2: `cfg_width` selects N. The values 1 to 8 select N directly, 0 is treated as 1, and any value above 8 is treated as 8. Both `cfg_width` and `cfg_settle` are captured only when a start is accepted.
- R3: A run presents the patterns 0, 1, 2, ... 2^N-1 on `pat_out` in rising order, one step at a time. `pat_out` bit 7 is the MSB and bit 0 the LSB, and every bit at position N or above stays low.
- R4: With settle delay D, each pattern stays on `pat_out` for exactly D+3 cycles, so `busy` is high for 2^N·(D+3) cycles. The stored result is the value `resp_in` had during the (D+1)-th cycle of that pattern; with D = 0 this is the pattern's first cycle.
- R5: Table entry k holds the pattern bits k (`rd_pat`), the integer value k (`rd_val`) and the stored result (`rd_res`). The read data appears on the cycle after `rd_addr` is presented.
- R6: `done` is high for exactly one cycle, and that cycle is the first idle cycle after the last record is written.
- R7: A start pulse while `busy` is high is ignored, along with any configuration change made during the run. A start in an idle cycle, including the cycle in which `done` is high, begins a new run on the next cycle.
- R8: While a run is in progress, the read outputs return all zeros.
- R9: A new run overwrites entries 0 to 2^N-1 with its own results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | 4 | Number of circuit inputs to sweep |
| cfg_settle | input | 24 | Settle delay in clock cycles |
| start | input | 1 | Begin a sweep when idle |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse at the end of a sweep |
| pat_out | output | 8 | Pattern driven to the circuit under test |
| resp_in | input | 1 | Response bit of the circuit under test (asynchronous) |
| rd_addr | input | 8 | Table read address |
| rd_pat | output | 8 | Pattern bits of the addressed record |
| rd_val | output | 8 | Integer value of the addressed record |
| rd_res | output | 1 | Stored result of the addressed record |

## Verification
Two events can coincide. A new start request can arrive in the same cycle that the finishing run raises `done`. A start can also arrive on the final capture cycle of a run, which is still busy.

The bench raises `start` in the exact cycle where it sees `done`. It then checks that `busy` rises on the next cycle and that the second sweep runs for its full length from pattern 0. A start pulse and configuration changes placed partway through a run must leave that run's length and pattern stepping unchanged. The combinational model on `resp_in` is evaluated for every stored entry, including runs with a zero settle delay, where a misplaced sample point would store a neighbouring pattern's response.

// File: rtl/ttab_pkg.sv
package ttab_pkg;

    localparam int PAT_W    = 8;
    localparam int DLY_W    = 24;
    localparam int WID_W    = $clog2(PAT_W + 1);
    localparam int DEPTH    = 1 << PAT_W;
    localparam int SYNC_LAT = 2;

    typedef logic [PAT_W-1:0] pat_t;

    typedef struct packed {
        pat_t bits;
        pat_t value;
        logic res;
    } rec_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    function automatic logic [WID_W-1:0] clamp_width(input logic [WID_W-1:0] w);
        if (w == '0)
            return WID_W'(1);
        if (w > WID_W'(PAT_W))
            return WID_W'(PAT_W);
        return w;
    endfunction

    function automatic pat_t last_pattern(input logic [WID_W-1:0] w);
        pat_t m;
        m = '0;
        for (int i = 0; i < PAT_W; i++)
            m[i] = (i < int'(w));
        return m;
    endfunction

endpackage

// File: rtl/ttab_sync.sv
module ttab_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst)
            shreg <= '0;
        else
            shreg <= {shreg[STAGES-2:0], d};
    end

    assign q = shreg[STAGES-1];
endmodule

// File: rtl/ttab_settle_timer.sv
module ttab_settle_timer #(
    parameter int DLY_W = 24,
    parameter int EXTRA = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    output logic             expired
);
    localparam int CNT_W = DLY_W + 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= CNT_W'(load_val) + CNT_W'(EXTRA);
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/ttab_pat_counter.sv
module ttab_pat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] last_val,
    output logic [W-1:0] count,
    output logic         at_last
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            count <= '0;
        else if (step)
            count <= count + W'(1);
    end

    assign at_last = (count == last_val);
endmodule

// File: rtl/ttab_result_ram.sv
module ttab_result_ram #(
    parameter int AW = 8,
    parameter int DW = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int ENTRIES = 1 << AW;

    logic [DW-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || !re)
            rdata <= '0;
        else
            rdata <= mem[raddr];
    end
endmodule

// File: rtl/ttab_sweeper.sv
module ttab_sweeper
    import ttab_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [WID_W-1:0] cfg_width,
    input  logic [DLY_W-1:0] cfg_settle,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [PAT_W-1:0] pat_out,
    input  logic             resp_in,
    input  logic [PAT_W-1:0] rd_addr,
    output logic [PAT_W-1:0] rd_pat,
    output logic [PAT_W-1:0] rd_val,
    output logic             rd_res
);
    state_e           state;
    logic [WID_W-1:0] width_q;
    logic [DLY_W-1:0] settle_q;
    logic             resp_s;
    logic             expired;
    logic             accept;
    logic             capture;
    logic             at_last;
    logic             tmr_load;
    logic [DLY_W-1:0] tmr_val;
    pat_t             cnt;
    rec_t             wr_rec;
    rec_t             rd_rec;

    // Synchronize the asynchronous response bit.
    ttab_sync #(.STAGES(SYNC_LAT)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (resp_in),
        .q   (resp_s)
    );

    assign accept   = (state == ST_IDLE) && start;
    assign capture  = (state == ST_RUN) && expired;
    assign tmr_load = accept || (capture && !at_last);
    assign tmr_val  = accept ? cfg_settle : settle_q;

    // The timer adds the synchronizer latency to the programmed delay.
    ttab_settle_timer #(.DLY_W(DLY_W), .EXTRA(SYNC_LAT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    ttab_pat_counter #(.W(PAT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .step     (capture && !at_last),
        .last_val (last_pattern(width_q)),
        .count    (cnt),
        .at_last  (at_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            done     <= 1'b0;
            width_q  <= WID_W'(1);
            settle_q <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_RUN;
                        width_q  <= clamp_width(cfg_width);
                        settle_q <= cfg_settle;
                    end
                end
                ST_RUN: begin
                    if (capture && at_last) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state == ST_RUN);
    assign pat_out = busy ? cnt : '0;

    assign wr_rec = '{bits: cnt, value: cnt, res: resp_s};

    ttab_result_ram #(.AW(PAT_W), .DW($bits(rec_t))) u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (capture),
        .waddr (cnt),
        .wdata (wr_rec),
        .re    (!busy),
        .raddr (rd_addr),
        .rdata (rd_rec)
    );

    assign rd_pat = rd_rec.bits;
    assign rd_val = rd_rec.value;
    assign rd_res = rd_rec.res;
endmodule

// File: rtl/ttab_sweeper_chk.sv
module ttab_sweeper_chk
    import ttab_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [PAT_W-1:0] pat_out,
    input logic [WID_W-1:0] width_q,
    input logic [PAT_W-1:0] rd_pat,
    input logic [PAT_W-1:0] rd_val,
    input logic             rd_res
);
    a_r1_idle_pattern_zero: assert property (@(posedge clk) disable iff (rst)
        !busy |-> pat_out == '0);

    a_r3_step_by_one: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && pat_out != $past(pat_out)) |-> pat_out == $past(pat_out) + PAT_W'(1));

    a_r3_upper_bits_low: assert property (@(posedge clk) disable iff (rst)
        busy |-> (pat_out >> width_q) == '0);

    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && $past(busy));

    a_r7_start_accept_idle: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> pat_out >= $past(pat_out));

    a_r8_read_zero_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> (rd_pat == '0 && rd_val == '0 && !rd_res));
endmodule

bind ttab_sweeper ttab_sweeper_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .pat_out (pat_out),
    .width_q (width_q),
    .rd_pat  (rd_pat),
    .rd_val  (rd_val),
    .rd_res  (rd_res)
);

// File: tb/ttab_sweeper_test.sv
module ttab_sweeper_test;
    localparam int CLK_P = 10;

    typedef struct packed {
        logic [3:0]  w;
        logic [23:0] d;
        logic [1:0]  f;
    } run_t;

    localparam int NRUN = 7;
    localparam run_t RUNS [NRUN] = '{
        '{4'd2,  24'd3, 2'd1},
        '{4'd4,  24'd0, 2'd0},
        '{4'd3,  24'd5, 2'd1},
        '{4'd3,  24'd0, 2'd2},   // R9: same entries, new function
        '{4'd8,  24'd1, 2'd2},
        '{4'd0,  24'd2, 2'd0},   // R2: 0 -> 1
        '{4'd12, 24'd0, 2'd1}    // R2: 12 -> 8
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_width = 4'd1;
    logic [23:0] cfg_settle = '0;
    logic        start = 1'b0;
    logic        busy, done, resp_in, rd_res;
    logic [7:0]  pat_out, rd_pat, rd_val;
    logic [7:0]  rd_addr = '0;
    logic [1:0]  fsel = '0;
    int          n_run = 0;
    int          n_fail = 0;

    function automatic logic fmodel(input logic [1:0] s, input logic [7:0] p);
        case (s)
            2'd0:    return (p[3] & p[2]) | (p[1] & p[0]);
            2'd1:    return (p[0] ^ p[1]) & p[2];
            default: return ^p;
        endcase
    endfunction

    function automatic int eff_width(input logic [3:0] w);
        if (w == 0) return 1;
        if (w > 8)  return 8;
        return int'(w);
    endfunction

    assign resp_in = fmodel(fsel, pat_out);

    always #(CLK_P/2) clk = ~clk;

    ttab_sweeper uut (
        .clk        (clk),
        .rst        (rst),
        .cfg_width  (cfg_width),
        .cfg_settle (cfg_settle),
        .start      (start),
        .busy       (busy),
        .done       (done),
        .pat_out    (pat_out),
        .resp_in    (resp_in),
        .rd_addr    (rd_addr),
        .rd_pat     (rd_pat),
        .rd_val     (rd_val),
        .rd_res     (rd_res)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // One sweep; start is raised on entry. poke adds mid-run disturbances.
    task automatic sweep(input logic [3:0] w, input logic [23:0] d, input logic [1:0] f,
                         input bit poke);
        int n   = eff_width(w);
        int per = int'(d) + 3;
        int tot = (1 << n) * per;
        int cyc = 0;
        int bad = 0;
        cfg_width  = w;
        cfg_settle = d;
        fsel       = f;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy && cyc < 100000) begin
            if (pat_out !== 8'(cyc / per)) bad++;
            start = 1'b0;
            if (poke && cyc == 3) begin
                start      = 1'b1;          // R7: ignored
                cfg_settle = d + 24'd9;
                cfg_width  = 4'd8;
                rd_addr    = 8'd1;
            end
            if (poke && cyc == 5)
                check(rd_pat == 0 && rd_val == 0 && rd_res == 0, "R8 read zero while busy",
                      int'(rd_val), 0);
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(bad == 0, "R3 pattern order and hold", bad, 0);
        check(cyc == tot, "R4 busy length", cyc, tot);
        check(done === 1'b1, "R6 done in first idle cycle", int'(done), 1);
        check(pat_out == 0, "R1 idle pattern", int'(pat_out), 0);
        @(negedge clk);
        check(done === 1'b0, "R6 done one cycle", int'(done), 0);
        bad = 0;
        for (int k = 0; k < (1 << n); k++) begin
            rd_addr = 8'(k);
            @(negedge clk);
            if (rd_pat != 8'(k) || rd_val != 8'(k) || rd_res != fmodel(f, 8'(k))) begin
                bad++;
                $display("FAIL R5 entry %0d: got %0d/%0d/%0d expected %0d/%0d/%0d",
                         k, rd_pat, rd_val, rd_res, k, k, fmodel(f, 8'(k)));
            end
        end
        n_run++;
        if (bad != 0) n_fail++;
    endtask

    initial begin
        #(CLK_P * 190000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && pat_out == 0, "R1 reset state",
              int'({busy, done}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 0 && pat_out == 0, "R1 idle after reset", int'(pat_out), 0);

        for (int i = 0; i < NRUN; i++)
            sweep(RUNS[i].w, RUNS[i].d, RUNS[i].f, 1'b0);

        // R7 / R2 / R8: start and config changes during a run are ignored
        sweep(4'd4, 24'd2, 2'd0, 1'b1);

        // R7: start in the done cycle begins a new run at once
        cfg_width  = 4'd1;
        cfg_settle = 24'd0;
        fsel       = 2'd2;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        check(done === 1'b1, "R6 done seen", int'(done), 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1 && pat_out == 0, "R7 start in done cycle accepted",
              int'(busy), 1);
        begin
            int c = 0;
            while (busy && c < 100) begin
                @(negedge clk);
                c++;
            end
            check(c == 6, "R7 chained run full length", c, 6);
        end

        // R1: reset in the middle of a run
        cfg_width  = 4'd3;
        cfg_settle = 24'd4;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(busy == 0 && done == 0 && pat_out == 0, "R1 reset during run",
              int'(pat_out), 0);
        rst = 1'b0;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule